// File: doc/BRIEF.md
# Register Rename Map with History Rollback

This block renames the register operands of one instruction thread. It keeps a table from each architectural register to its current physical register, a FIFO of unused physical registers, one ready bit per physical register, and a circular history of every destination rename. Each history record holds the sequence number, the flattened architectural index, the newly allocated physical register and the one it replaced.

A rename request looks up two source operands and returns their physical indices and ready bits. If the instruction has a destination, the block also takes a register from the free FIFO, points the map at it and appends a history record. A squash request undoes history records that are younger than a given sequence number, starting with the youngest. A commit request retires records at or below a given sequence number, starting with the oldest, and releases the registers they replaced. Squash and commit each walk one record per cycle. While a walk runs, `walk_busy` is high.

Integer architectural tags come first in the map. Floating-point tags start at a tag base and are folded in directly after the integer registers.

Top module: `rename_rollback_map`

## Requirements
- R1: After reset, flattened architectural register a maps to physical register a, every ready bit is set, and `free_count` equals NUM_PHYS minus the number of architectural registers.
- R2: A tag below FP_BASE flattens to itself. A tag t at or above FP_BASE flattens to t - FP_BASE + INT_REGS.
- R3: An accepted rename with a destination has the following effects:
  - `dst_phys` is the oldest entry of the free FIFO, which at reset holds NUM_ARCH..NUM_PHYS-1 in ascending order.
  - `dst_prev` is the current mapping of the destination.
  - Source lookups in the same cycle see the mapping from before the rename.
  - From the next cycle, the destination maps to `dst_phys`.
- R4: A source lookup returns the ready bit of the mapped register. A register becomes not ready when it is allocated, and nothing in this block sets it ready again.
- R5: A rename with a destination is refused (`ren_accept` low, no state change) when `free_count` is 0. A rename without a destination is accepted and adds no history record.
- R6: A squash walks from the youngest record while its sequence number is greater than the target. Each step restores the map to the previous register, appends the new register to the free FIFO tail, and drops the record.
- R7: A commit walks from the oldest record while its sequence number is at most the target. Each step appends the previous register to the free FIFO tail and drops the record. The map is not changed.
- R8: A commit changes nothing when the history is empty or when its oldest record is younger than the target.
- R9: Only one request is taken per cycle, in the priority order squash, then commit, then rename. `walk_busy` is high from the cycle after a squash or commit is taken until its walk ends. While it is high, new requests are ignored and renames are refused.
- R10: The free-register count plus the number of live history records always equals NUM_PHYS minus the number of architectural registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_seq | input | SEQ_W | Sequence number of the renamed instruction |
| ren_src0 | input | TAG_W | Source 0 architectural tag |
| ren_src1 | input | TAG_W | Source 1 architectural tag |
| ren_has_dst | input | 1 | Instruction writes a destination |
| ren_dst | input | TAG_W | Destination architectural tag |
| ren_accept | output | 1 | Rename taken this cycle |
| src0_phys | output | clog2(NUM_PHYS) | Physical register of source 0 |
| src0_ready | output | 1 | Source 0 ready bit |
| src1_phys | output | clog2(NUM_PHYS) | Physical register of source 1 |
| src1_ready | output | 1 | Source 1 ready bit |
| dst_phys | output | clog2(NUM_PHYS) | Register allocated to the destination |
| dst_prev | output | clog2(NUM_PHYS) | Register the destination mapped to before |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash target sequence number |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Commit target sequence number |
| walk_busy | output | 1 | Squash or commit walk in progress |
| free_count | output | clog2(NUM_PHYS-INT_REGS-FP_REGS+1) | Registers left in the free FIFO |

## Verification
The assertions check on every cycle that:
- registers are conserved between the free FIFO and the history;
- neither storage overflows or underflows;
- allocation clears the ready bit;
- no rename is taken while a walk is running.

Only the bench scenarios can show the rest:
- which registers come out of the free FIFO, and in what order;
- that a squash restores exactly the younger mappings and leaves older ones in place;
- that a commit leaves the map untouched;
- that the priority order holds when requests collide.

The bench sweeps every architectural tag against a model after each walk. It also runs a long pseudo-random mix of renames, squashes and commits through the full and empty boundaries of both storages.

// File: rtl/rn_pkg.sv
package rn_pkg;
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_SQUASH = 2'd1,
      WK_COMMIT = 2'd2
   } walk_e;

   // Integers occupy the low map slots; floating-point tags follow them.
   function automatic int flatten_tag(int tag, int fp_base, int int_regs);
      return (tag < fp_base) ? tag : tag - fp_base + int_regs;
   endfunction
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
   parameter int DEPTH = 8,
   parameter int PW    = 5,
   parameter int BASE  = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pop,
   input  logic                         push,
   input  logic [PW-1:0]                push_data,
   output logic [PW-1:0]                head_data,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rn_free_fifo needs DEPTH >= 2");
      end
   endgenerate

   logic [PW-1:0] slot_q [DEPTH];
   logic [IW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [IW-1:0] wrap_inc(logic [IW-1:0] p);
      return (p == IW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= PW'(BASE + i);
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= CW'(DEPTH);
      end else begin
         if (pop)  head_q <= wrap_inc(head_q);
         if (push) begin
            slot_q[tail_q] <= push_data;
            tail_q         <= wrap_inc(tail_q);
         end
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   assign head_data = slot_q[head_q];
   assign count     = cnt_q;

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |-> cnt_q < CW'(DEPTH));
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0);
endmodule

// File: rtl/rn_hist_ring.sv
module rn_hist_ring #(
   parameter int DEPTH = 8,
   parameter int EW    = 22
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [EW-1:0]                push_data,
   input  logic                         pop_young,
   input  logic                         pop_old,
   output logic [EW-1:0]                young_data,
   output logic [EW-1:0]                old_data,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full
);
   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rn_hist_ring needs DEPTH >= 2");
      end
   endgenerate

   logic [EW-1:0] ent_q [DEPTH];
   logic [IW-1:0] head_q, tail_q, tail_dec;
   logic [CW-1:0] cnt_q;

   assign tail_dec = (tail_q == '0) ? IW'(DEPTH-1) : tail_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) begin
            ent_q[tail_q] <= push_data;
            tail_q        <= (tail_q == IW'(DEPTH-1)) ? '0 : tail_q + 1'b1;
         end else if (pop_young) begin
            tail_q <= tail_dec;
         end
         if (pop_old) head_q <= (head_q == IW'(DEPTH-1)) ? '0 : head_q + 1'b1;
         cnt_q <= cnt_q + CW'(push) - CW'(pop_young) - CW'(pop_old);
      end
   end

   assign young_data = ent_q[tail_dec];
   assign old_data   = ent_q[head_q];
   assign count      = cnt_q;
   assign full       = (cnt_q == CW'(DEPTH));

   p_ring_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_ring_pop_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_young || pop_old) |-> cnt_q != '0);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int N_ARCH = 12,
   parameter int N_PHYS = 20,
   parameter int AW     = 4,
   parameter int PW     = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_a0,
   input  logic [AW-1:0] rd_a1,
   input  logic [AW-1:0] rd_a2,
   output logic [PW-1:0] rd_p0,
   output logic [PW-1:0] rd_p1,
   output logic [PW-1:0] rd_p2,
   output logic          rd_r0,
   output logic          rd_r1,
   input  logic          wr_en,
   input  logic          wr_alloc,
   input  logic [AW-1:0] wr_arch,
   input  logic [PW-1:0] wr_phys
);
   logic [PW-1:0]     map_q [N_ARCH];
   logic [N_PHYS-1:0] rdy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ARCH; i++) map_q[i] <= PW'(i);
         rdy_q <= '1;
      end else if (wr_en) begin
         map_q[wr_arch] <= wr_phys;
         if (wr_alloc) rdy_q[wr_phys] <= 1'b0;
      end
   end

   assign rd_p0 = map_q[rd_a0];
   assign rd_p1 = map_q[rd_a1];
   assign rd_p2 = map_q[rd_a2];
   assign rd_r0 = rdy_q[rd_p0];
   assign rd_r1 = rdy_q[rd_p1];

   p_alloc_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_alloc |=> !rdy_q[$past(wr_phys)]);
endmodule

// File: rtl/rename_rollback_map.sv
module rename_rollback_map #(
   parameter int INT_REGS = 8,
   parameter int FP_REGS  = 4,
   parameter int FP_BASE  = 16,
   parameter int TAG_W    = 5,
   parameter int NUM_PHYS = 20,
   parameter int SEQ_W    = 8
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           ren_valid,
   input  logic [SEQ_W-1:0]                               ren_seq,
   input  logic [TAG_W-1:0]                               ren_src0,
   input  logic [TAG_W-1:0]                               ren_src1,
   input  logic                                           ren_has_dst,
   input  logic [TAG_W-1:0]                               ren_dst,
   output logic                                           ren_accept,
   output logic [$clog2(NUM_PHYS)-1:0]                    src0_phys,
   output logic                                           src0_ready,
   output logic [$clog2(NUM_PHYS)-1:0]                    src1_phys,
   output logic                                           src1_ready,
   output logic [$clog2(NUM_PHYS)-1:0]                    dst_phys,
   output logic [$clog2(NUM_PHYS)-1:0]                    dst_prev,
   input  logic                                           sq_valid,
   input  logic [SEQ_W-1:0]                               sq_seq,
   input  logic                                           cm_valid,
   input  logic [SEQ_W-1:0]                               cm_seq,
   output logic                                           walk_busy,
   output logic [$clog2(NUM_PHYS-INT_REGS-FP_REGS+1)-1:0] free_count
);
   import rn_pkg::*;

   localparam int NUM_ARCH = INT_REGS + FP_REGS;
   localparam int AW       = $clog2(NUM_ARCH);
   localparam int PW       = $clog2(NUM_PHYS);
   localparam int FREE_N   = NUM_PHYS - NUM_ARCH;
   localparam int CW       = $clog2(FREE_N + 1);
   localparam int EW       = SEQ_W + AW + 2 * PW;

   generate
      if (FREE_N < 2) begin : g_bad_phys
         $error("NUM_PHYS must exceed the architectural count by at least 2");
      end
      if (FP_REGS > 0 && FP_BASE < INT_REGS) begin : g_bad_base
         $error("FP_BASE must not overlap the integer tags");
      end
      if ((1 << TAG_W) < FP_BASE + FP_REGS) begin : g_bad_tag
         $error("TAG_W too narrow for the floating-point tags");
      end
   endgenerate

   // Tag flattening: with no floating-point file the tag is the index.
   logic [AW-1:0] s0_a, s1_a, d_a;
   generate
      if (FP_REGS > 0) begin : g_flat_fp
         assign s0_a = AW'(flatten_tag(int'(ren_src0), FP_BASE, INT_REGS));
         assign s1_a = AW'(flatten_tag(int'(ren_src1), FP_BASE, INT_REGS));
         assign d_a  = AW'(flatten_tag(int'(ren_dst),  FP_BASE, INT_REGS));
      end else begin : g_flat_int
         assign s0_a = AW'(ren_src0);
         assign s1_a = AW'(ren_src1);
         assign d_a  = AW'(ren_dst);
      end
   endgenerate

   walk_e            mode_q;
   logic [SEQ_W-1:0] tgt_q;
   logic             idle, take_sq, take_cm, do_alloc, sq_step, cm_step;
   logic [EW-1:0]    young_d, old_d;
   logic [CW-1:0]    hist_cnt, fl_cnt;
   logic             hist_full;
   logic [PW-1:0]    fl_head;

   logic [SEQ_W-1:0] y_seq, o_seq;
   logic [AW-1:0]    y_arch;
   logic [PW-1:0]    y_new, y_prev, o_prev;

   assign y_seq  = young_d[EW-1 -: SEQ_W];
   assign y_arch = young_d[2*PW +: AW];
   assign y_new  = young_d[PW +: PW];
   assign y_prev = young_d[0 +: PW];
   assign o_seq  = old_d[EW-1 -: SEQ_W];
   assign o_prev = old_d[0 +: PW];

   assign idle       = (mode_q == WK_IDLE);
   assign take_sq    = idle && sq_valid;
   assign take_cm    = idle && !sq_valid && cm_valid;
   assign ren_accept = idle && ren_valid && !sq_valid && !cm_valid &&
                       (!ren_has_dst || fl_cnt != '0);
   assign do_alloc   = ren_accept && ren_has_dst;
   assign sq_step    = (mode_q == WK_SQUASH) && hist_cnt != '0 && y_seq > tgt_q;
   assign cm_step    = (mode_q == WK_COMMIT) && hist_cnt != '0 && o_seq <= tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= WK_IDLE;
         tgt_q  <= '0;
      end else if (take_sq) begin
         mode_q <= WK_SQUASH;
         tgt_q  <= sq_seq;
      end else if (take_cm) begin
         mode_q <= WK_COMMIT;
         tgt_q  <= cm_seq;
      end else if (!idle && !sq_step && !cm_step) begin
         mode_q <= WK_IDLE;
      end
   end

   rn_map_table #(.N_ARCH(NUM_ARCH), .N_PHYS(NUM_PHYS), .AW(AW), .PW(PW)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a0    (s0_a),
      .rd_a1    (s1_a),
      .rd_a2    (d_a),
      .rd_p0    (src0_phys),
      .rd_p1    (src1_phys),
      .rd_p2    (dst_prev),
      .rd_r0    (src0_ready),
      .rd_r1    (src1_ready),
      .wr_en    (do_alloc || sq_step),
      .wr_alloc (do_alloc),
      .wr_arch  (sq_step ? y_arch : d_a),
      .wr_phys  (sq_step ? y_prev : fl_head)
   );

   rn_free_fifo #(.DEPTH(FREE_N), .PW(PW), .BASE(NUM_ARCH)) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (do_alloc),
      .push      (sq_step || cm_step),
      .push_data (sq_step ? y_new : o_prev),
      .head_data (fl_head),
      .count     (fl_cnt)
   );

   rn_hist_ring #(.DEPTH(FREE_N), .EW(EW)) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (do_alloc),
      .push_data  ({ren_seq, d_a, fl_head, dst_prev}),
      .pop_young  (sq_step),
      .pop_old    (cm_step),
      .young_data (young_d),
      .old_data   (old_d),
      .count      (hist_cnt),
      .full       (hist_full)
   );

   assign dst_phys   = fl_head;
   assign walk_busy  = !idle;
   assign free_count = fl_cnt;

   p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fl_cnt) + 32'(hist_cnt) == FREE_N);
   p_full_means_empty_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hist_full |-> fl_cnt == '0);
   p_busy_refuses_r9: assert property (@(posedge clk) disable iff (!rst_n)
      walk_busy |-> !ren_accept);
   p_walk_ends_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      walk_busy && !sq_step && !cm_step |=> !walk_busy);
endmodule

// File: tb/tb_rename_rollback_map.sv
module tb_rename_rollback_map;
   localparam int NA = 12;
   localparam int NP = 20;

   logic clk = 0, rst_n = 0;
   logic ren_valid = 0, ren_has_dst = 0, sq_valid = 0, cm_valid = 0;
   logic [7:0] ren_seq = 0, sq_seq = 0, cm_seq = 0;
   logic [4:0] ren_src0 = 0, ren_src1 = 0, ren_dst = 0;
   logic       ren_accept, src0_ready, src1_ready, walk_busy;
   logic [4:0] src0_phys, src1_phys, dst_phys, dst_prev;
   logic [3:0] free_count;

   always #4 clk = ~clk;

   rename_rollback_map dut (
      .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_seq(ren_seq),
      .ren_src0(ren_src0), .ren_src1(ren_src1), .ren_has_dst(ren_has_dst),
      .ren_dst(ren_dst), .ren_accept(ren_accept), .src0_phys(src0_phys),
      .src0_ready(src0_ready), .src1_phys(src1_phys), .src1_ready(src1_ready),
      .dst_phys(dst_phys), .dst_prev(dst_prev), .sq_valid(sq_valid),
      .sq_seq(sq_seq), .cm_valid(cm_valid), .cm_seq(cm_seq),
      .walk_busy(walk_busy), .free_count(free_count)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   int m_map [NA];
   bit m_rdy [NP];
   int m_free[$];
   int h_seq[$], h_arch[$], h_new[$], h_prev[$];
   int cur_seq = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int tag_of(int a);
      return (a < 8) ? a : a - 8 + 16;
   endfunction
   function automatic int flat(int t);
      return (t < 16) ? t : t - 16 + 8;
   endfunction

   task automatic check_state(string req);
      for (int a = 0; a < NA; a++) begin
         @(negedge clk);
         ren_src0 = 5'(tag_of(a));
         ren_src1 = 5'(tag_of(NA - 1 - a));
         #1;
         chk(int'(src0_phys) == m_map[a], req, int'(src0_phys), m_map[a]);
         chk(src0_ready == m_rdy[m_map[a]], req, int'(src0_ready), int'(m_rdy[m_map[a]]));
         chk(int'(src1_phys) == m_map[NA-1-a], req, int'(src1_phys), m_map[NA-1-a]);
      end
      chk(int'(free_count) == m_free.size(), req, int'(free_count), m_free.size());
   endtask

   task automatic do_rename(int s0, int s1, bit has, int d, string req);
      bit exp_acc;
      int fd;
      @(negedge clk);
      cur_seq++;
      ren_valid = 1; ren_seq = 8'(cur_seq); ren_src0 = 5'(s0); ren_src1 = 5'(s1);
      ren_has_dst = has; ren_dst = 5'(d);
      #1;
      fd = flat(d);
      exp_acc = !has || m_free.size() > 0;
      chk(ren_accept == exp_acc, req, int'(ren_accept), int'(exp_acc));
      chk(int'(src0_phys) == m_map[flat(s0)], req, int'(src0_phys), m_map[flat(s0)]);
      chk(src0_ready == m_rdy[m_map[flat(s0)]], req, int'(src0_ready), int'(m_rdy[m_map[flat(s0)]]));
      chk(int'(src1_phys) == m_map[flat(s1)], req, int'(src1_phys), m_map[flat(s1)]);
      if (has && exp_acc) begin
         chk(int'(dst_phys) == m_free[0], req, int'(dst_phys), m_free[0]);
         chk(int'(dst_prev) == m_map[fd], req, int'(dst_prev), m_map[fd]);
      end
      @(posedge clk);
      #1;
      ren_valid = 0;
      if (has && exp_acc) begin
         int np;
         np = m_free.pop_front();
         h_seq.push_back(cur_seq); h_arch.push_back(fd);
         h_new.push_back(np); h_prev.push_back(m_map[fd]);
         m_map[fd] = np;
         m_rdy[np] = 0;
      end
   endtask

   task automatic wait_walk(string req);
      int guard = 0;
      @(negedge clk);
      chk(walk_busy == 1'b1, req, int'(walk_busy), 1);
      while (walk_busy && guard < 40) begin
         ren_valid = 1; ren_has_dst = 0;
         #1;
         chk(ren_accept == 1'b0, "R9", int'(ren_accept), 0);
         ren_valid = 0;
         guard++;
         @(negedge clk);
      end
   endtask

   task automatic model_squash(int tgt);
      while (h_seq.size() > 0 && h_seq[$] > tgt) begin
         m_map[h_arch[$]] = h_prev[$];
         m_free.push_back(h_new[$]);
         void'(h_seq.pop_back()); void'(h_arch.pop_back());
         void'(h_new.pop_back()); void'(h_prev.pop_back());
      end
   endtask

   task automatic model_commit(int tgt);
      while (h_seq.size() > 0 && h_seq[0] <= tgt) begin
         m_free.push_back(h_prev[0]);
         void'(h_seq.pop_front()); void'(h_arch.pop_front());
         void'(h_new.pop_front()); void'(h_prev.pop_front());
      end
   endtask

   task automatic do_squash(int tgt, string req);
      @(negedge clk);
      sq_valid = 1; sq_seq = 8'(tgt);
      @(posedge clk); #1; sq_valid = 0;
      wait_walk(req);
      model_squash(tgt);
      check_state(req);
   endtask

   task automatic do_commit(int tgt, string req);
      @(negedge clk);
      cm_valid = 1; cm_seq = 8'(tgt);
      @(posedge clk); #1; cm_valid = 0;
      wait_walk(req);
      model_commit(tgt);
      check_state(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lcg = 12345;
      for (int i = 0; i < NA; i++) m_map[i] = i;
      for (int i = 0; i < NP; i++) m_rdy[i] = 1;
      for (int i = NA; i < NP; i++) m_free.push_back(i);
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 / R2: identity map, all ready, tags flattened integers first
      check_state("R1 R2 reset");

      // R3 / R4: fill the free FIFO, sources equal to destination see old map
      do_rename(0, 1, 1, 0, "R3");
      do_rename(0, 16, 1, 1, "R3");
      do_rename(16, 0, 1, 16, "R3");
      do_rename(17, 17, 1, 17, "R3");
      do_rename(2, 3, 1, 2, "R3");
      do_rename(3, 16, 1, 3, "R3");
      do_rename(18, 0, 1, 18, "R3");
      do_rename(0, 19, 1, 0, "R4");
      check_state("R4 after fill");

      // R5: refused with no free register, accepted without a destination
      do_rename(1, 2, 1, 5, "R5 refuse");
      do_rename(1, 2, 0, 5, "R5 no dst");
      check_state("R5");

      // R6: squash rolls back younger records
      do_squash(5, "R6");
      // R7: commit releases older previous mappings
      do_commit(3, "R7");
      // R8: commit target older than oldest record
      do_commit(1, "R8 old");

      // R9: squash beats commit and rename in the same cycle
      @(negedge clk);
      cur_seq++;
      sq_valid = 1; sq_seq = 8'(4); cm_valid = 1; cm_seq = 8'(200);
      ren_valid = 1; ren_has_dst = 1; ren_dst = 5'(6); ren_seq = 8'(cur_seq);
      #1;
      chk(ren_accept == 1'b0, "R9 priority", int'(ren_accept), 0);
      @(posedge clk); #1;
      sq_valid = 0; cm_valid = 0; ren_valid = 0;
      wait_walk("R9");
      model_squash(4);
      check_state("R9 squash won");

      // Pseudo-random mix across full and empty boundaries
      for (int k = 0; k < 150; k++) begin
         int op;
         lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
         op = (lcg >> 8) % 10;
         if (op == 0) begin
            do_squash(cur_seq - ((lcg >> 4) % 4), "R6 mix");
         end else if (op == 1) begin
            do_commit((h_seq.size() > 0 ? h_seq[0] : cur_seq) + ((lcg >> 4) % 3), "R7 mix");
         end else begin
            do_rename(tag_of((lcg >> 12) % NA), tag_of((lcg >> 16) % NA),
                      ((lcg >> 20) % 5) != 0, tag_of((lcg >> 3) % NA), "R3 mix");
         end
      end

      // R8: commit everything, then commit on an empty history
      do_commit(250, "R7 drain");
      do_commit(250, "R8 empty");
      chk(int'(free_count) == NP - NA, "R10", int'(free_count), NP - NA);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule